// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 32768 bytes. The host raises a request with a 15-bit word address, a direction flag and, for stores, a data byte. The block turns each request into a strobe sequence on the memory pins that meets the memory's timing limits. It drives three active-low strobes (select, write, output) and the address. The shared data bus is split into an outgoing byte, an incoming byte and a driver enable.

Every timing limit is a parameter in nanoseconds. The block converts each limit into a whole number of clock cycles: the ceiling of the limit divided by the clock-period parameter, and never less than one. Each phase of an access lasts the largest cycle count that applies to it. A read holds select and output enable low for the access window and captures the bus on the last cycle of that window. It then keeps both strobes high long enough for the memory to release the bus. A write lowers select and write enable together. It turns its own bus drivers on one cycle into the pulse and keeps them on for a recovery cycle after the pulse ends.

The host sees ready low from the cycle after acceptance until the access has finished. A request is accepted only on a clock edge where ready is high. A host that finds the block busy keeps its request raised until ready returns.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, ready is high, all three strobes are high and the data drivers are off.
- R2: A read holds select and output enable low and write enable high, and returns the byte stored at the requested address on `host_rdata` by the time ready is high again.
- R3: With a 10 ns clock, output enable stays low for exactly 7 cycles. This is the largest of ceil(70/10) for address and select access and ceil(35/10) for output-enable access. The bus is sampled in the last of those cycles.
- R4: After the read window, select and output enable stay high for max(ceil(30/10), ceil(70/10) − 7) = 3 cycles before ready rises. From acceptance to ready high takes 11 cycles.
- R5: Write enable is never low unless select is low. The write-enable pulse lasts max(ceil(50/10), ceil(60/10), ceil(30/10)+1) = 6 cycles.
- R6: While write enable is low, the address is unchanged. The address and select have been valid for at least 60 ns at the end of the pulse, and the write data has been driven unchanged for at least 30 ns.
- R7: Output enable is high whenever write enable is low or the data drivers are on. The drivers turn on only after write enable has been low for one cycle.
- R8: After the pulse, one recovery cycle (max(1, ceil(70/10) − 6)) keeps the data driven with all strobes high. From acceptance of a write to ready high takes 8 cycles.
- R9: Ready is low from acceptance until completion. A request present only while ready is low is never started. A request held through a busy period is served once ready returns.
- R10: The controller never drives the data bus while the memory may still be driving it, including a write that directly follows a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken on an edge where ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Word address |
| host_wdata | input | 8 | Byte to store |
| host_ready | output | 1 | High when idle and able to accept |
| host_rdata | output | 8 | Byte captured by the last read |
| sram_cs_n | output | 1 | Memory select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_out | output | 8 | Byte driven onto the shared data bus |
| sram_dq_in | input | 8 | Byte read from the shared data bus |
| sram_dq_oe | output | 1 | Enables the controller's data drivers |

## Verification
The hardest case to reach from the ports is a bus conflict at a read-to-write turnaround. The memory keeps driving for up to 30 ns after output enable rises, so a write issued straight after a read is the only place where both sides could drive the bus at once. The stimulus table places writes directly after reads at the same and at different addresses. The bench's memory model tracks, in nanoseconds, how long it keeps driving after each read and reports any overlap with the controller's drivers. The same model returns a poison byte whenever a read window is shorter than the access limits, so a shortened window appears as wrong read data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_RREL   = 3'd2,
        PH_WPULSE = 3'd3,
        PH_WREC   = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // ceiling of ns / period, at least one cycle
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count   = cnt_q;
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned RD_CYC = 7,
    parameter int unsigned REL_CYC = 3,
    parameter int unsigned WP_CYC = 6,
    parameter int unsigned WR_CYC = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    wr,
    output logic    accept,
    output logic    sample,
    output logic    ready,
    output strobe_t strobe
);
    phase_e           phase_q, phase_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_count;
    logic             tmr_done;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_count),
        .expired  (tmr_done)
    );

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req) begin
                    tmr_load = 1'b1;
                    if (wr) begin
                        phase_d = PH_WPULSE;
                        tmr_val = CNT_W'(WP_CYC - 1);
                    end else begin
                        phase_d = PH_READ;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_READ: begin
                if (tmr_done) begin
                    phase_d  = PH_RREL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REL_CYC - 1);
                end
            end
            PH_RREL: begin
                if (tmr_done) phase_d = PH_IDLE;
            end
            PH_WPULSE: begin
                if (tmr_done) begin
                    phase_d  = PH_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WR_CYC - 1);
                end
            end
            PH_WREC: begin
                if (tmr_done) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    // strobes are decoded only from flops, never from host inputs
    always_comb begin
        strobe = STROBE_IDLE;
        unique case (phase_q)
            PH_READ: begin
                strobe.cs_n = 1'b0;
                strobe.oe_n = 1'b0;
            end
            PH_WPULSE: begin
                strobe.cs_n  = 1'b0;
                strobe.we_n  = 1'b0;
                strobe.dq_oe = (tmr_count != CNT_W'(WP_CYC - 1));
            end
            PH_WREC: begin
                strobe.dq_oe = 1'b1;
            end
            default: strobe = STROBE_IDLE;
        endcase
    end

    assign ready  = (phase_q == PH_IDLE);
    assign accept = ready && req;
    assign sample = (phase_q == PH_READ) && tmr_done;
endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              sample,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (sample) rdata_q <= bus_in;
    end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 15,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned T_RC_NS = 70,
    parameter int unsigned T_AA_NS = 70,
    parameter int unsigned T_OE_NS = 35,
    parameter int unsigned T_HZ_NS = 30,
    parameter int unsigned T_WC_NS = 70,
    parameter int unsigned T_WP_NS = 50,
    parameter int unsigned T_AW_NS = 60,
    parameter int unsigned T_DW_NS = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);
    localparam int unsigned C_RC = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int unsigned C_AA = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int unsigned C_OE = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int unsigned C_HZ = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned C_WC = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned C_WP = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned C_AW = ns_to_cyc(T_AW_NS, CLK_NS);
    localparam int unsigned C_DW = ns_to_cyc(T_DW_NS, CLK_NS);

    localparam int unsigned RD_CYC  = umax(C_AA, C_OE);
    localparam int unsigned REL_CYC = (C_RC > RD_CYC) ? umax(C_HZ, C_RC - RD_CYC) : C_HZ;
    localparam int unsigned WP_CYC  = umax(umax(C_WP, C_AW), C_DW + 1);
    localparam int unsigned WR_CYC  = (C_WC > WP_CYC) ? (C_WC - WP_CYC) : 1;
    localparam int unsigned MAX_CYC = umax(umax(RD_CYC, REL_CYC), umax(WP_CYC, WR_CYC));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic    accept;
    logic    sample;
    strobe_t strobe;

    sram_access_seq #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .REL_CYC (REL_CYC),
        .WP_CYC  (WP_CYC),
        .WR_CYC  (WR_CYC)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (host_req),
        .wr     (host_wr),
        .accept (accept),
        .sample (sample),
        .ready  (host_ready),
        .strobe (strobe)
    );

    sram_ctl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .sample    (sample),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .bus_in    (sram_dq_in),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_out),
        .rdata_q   (host_rdata)
    );

    assign sram_cs_n  = strobe.cs_n;
    assign sram_we_n  = strobe.we_n;
    assign sram_oe_n  = strobe.oe_n;
    assign sram_dq_oe = strobe.dq_oe;
endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ready,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out
);
    // R1 / R9: an idle controller leaves the memory deselected
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    // R5: write enable only under select
    a_r5_we_under_cs: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_cs_n);

    // R7: output enable stays high during writes and while driving
    a_r7_oe_high_writing: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n || sram_dq_oe) |-> sram_oe_n);

    // R7: drivers switch on only after write enable has been low a cycle
    a_r7_drive_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dq_oe) |-> (!sram_we_n && !$past(sram_we_n)));

    // R6: address is steady while selected
    a_r6_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    // R6: data is steady while driven
    a_r6_data_steady: assert property (@(posedge clk) disable iff (rst)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

    // R8: write enable rises while the data is still driven
    a_r8_hold_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> sram_dq_oe);

    // R4: the cycle output enable rises belongs to the release interval
    a_r4_release_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> !host_ready);
endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_ready  (host_ready),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_oe  (sram_dq_oe),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out)
);

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 32768;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_RD  = mx(cyc(70), cyc(35));
    localparam int EXP_REL = mx(cyc(30), cyc(70) - EXP_RD);
    localparam int EXP_WP  = mx(mx(cyc(50), cyc(60)), cyc(30) + 1);
    localparam int EXP_WR  = mx(1, cyc(70) - EXP_WP);

    logic        clk = 1'b0;
    logic        rst;
    logic        host_req, host_wr;
    logic [14:0] host_addr;
    logic [7:0]  host_wdata;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_sram_ctrl dut (
        .clk (clk), .rst (rst),
        .host_req (host_req), .host_wr (host_wr),
        .host_addr (host_addr), .host_wdata (host_wdata),
        .host_ready (host_ready), .host_rdata (host_rdata),
        .sram_cs_n (sram_cs_n), .sram_we_n (sram_we_n), .sram_oe_n (sram_oe_n),
        .sram_addr (sram_addr), .sram_dq_out (sram_dq_out),
        .sram_dq_in (sram_dq_in), .sram_dq_oe (sram_dq_oe)
    );

    // ---------------- behavioural memory with timing in ns ----------------
    logic [7:0]  mem_arr [0:WORDS-1];
    logic [7:0]  ref_arr [0:WORDS-1];
    logic [14:0] prev_addr = '0;
    int addr_ns = 0, cs_ns = 0, oe_ns = 0, rel_ns = 0;
    int wp_ns = 0, aw_ns = 0, dw_ns = 0;
    bit in_wr = 0, mem_on = 0, last_on = 0;
    logic [7:0]  last_dq = '0, w_data = '0;
    logic [14:0] w_addr = '0;

    initial sram_dq_in = 8'hEE;

    always @(negedge clk) begin
        if (!rst) begin
            bit active;
            active  = !sram_cs_n && !sram_oe_n && sram_we_n;
            addr_ns = (sram_addr == prev_addr) ? addr_ns + CLK_PERIOD : CLK_PERIOD;
            prev_addr = sram_addr;
            cs_ns = !sram_cs_n ? cs_ns + CLK_PERIOD : 0;
            oe_ns = active ? oe_ns + CLK_PERIOD : 0;
            if (active) begin
                rel_ns = 30; mem_on = 1;
            end else if (rel_ns > 0) begin
                mem_on = 1; rel_ns = rel_ns - CLK_PERIOD;
            end else begin
                mem_on = 0;
            end
            sram_dq_in <= (active && addr_ns >= 70 && cs_ns >= 70 && oe_ns >= 35)
                          ? mem_arr[sram_addr] : 8'hEE;
            if (mem_on && sram_dq_oe) begin
                errors++; checks++;
                $display("FAIL R10 bus contention at %0t: got drive 1 exp 0", $time);
            end
            if (!sram_cs_n && !sram_we_n) begin
                in_wr = 1;
                wp_ns += CLK_PERIOD;
                aw_ns = (addr_ns < cs_ns) ? addr_ns : cs_ns;
                if (sram_dq_oe)
                    dw_ns = (last_on && sram_dq_out == last_dq) ? dw_ns + CLK_PERIOD : CLK_PERIOD;
                else
                    dw_ns = 0;
                w_addr = sram_addr;
                w_data = sram_dq_oe ? sram_dq_out : 8'hEE;
            end else if (in_wr) begin
                checks += 3;
                if (wp_ns < 50) begin
                    errors++; $display("FAIL R5 write pulse ns got %0d exp >= 50", wp_ns);
                end
                if (aw_ns < 60) begin
                    errors++; $display("FAIL R6 address valid ns got %0d exp >= 60", aw_ns);
                end
                if (dw_ns < 30) begin
                    errors++; $display("FAIL R6 data setup ns got %0d exp >= 30", dw_ns);
                end
                mem_arr[w_addr] = w_data;
                in_wr = 0; wp_ns = 0;
            end
            last_on = sram_dq_oe;
            last_dq = sram_dq_out;
        end
    end

    // ---------------- stimulus ----------------
    typedef struct packed {
        logic        wr;
        logic [14:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 15'h0000, 8'h00},
        '{1'b1, 15'h0000, 8'hA5},
        '{1'b0, 15'h0000, 8'h00},
        '{1'b1, 15'h7FFF, 8'h3C},
        '{1'b0, 15'h7FFF, 8'h00},
        '{1'b0, 15'h1234, 8'h00},
        '{1'b1, 15'h1234, 8'h00},
        '{1'b1, 15'h1234, 8'hFF},
        '{1'b0, 15'h1234, 8'h00},
        '{1'b1, 15'h4000, 8'h81},
        '{1'b0, 15'h4000, 8'h00},
        '{1'b0, 15'h7FFE, 8'h00}
    };

    logic [7:0] rd_v;
    int lat_v, oe_v, we_v;

    task automatic check(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h exp %0h", what, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [14:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat, output int oe_c, output int we_c);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        while (!host_ready) @(negedge clk);
        @(negedge clk);
        host_req = 1'b0;
        lat = 1; oe_c = 0; we_c = 0;
        while (!host_ready) begin
            if (!sram_oe_n) oe_c++;
            if (!sram_we_n) we_c++;
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: got hang exp completion");
        summary();
    end

    initial begin
        rst = 1'b1; host_req = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            mem_arr[i] = 8'(i) ^ 8'h5A;
            ref_arr[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(host_ready && sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe,
              "R1 strobes in reset", {host_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b11110);
        rst = 1'b0;
        @(negedge clk);
        check(host_ready && sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe,
              "R1 strobes after reset", {host_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b11110);

        // table walk
        for (int k = 0; k < NV; k++) begin
            access(VECS[k].wr, VECS[k].addr, VECS[k].data, rd_v, lat_v, oe_v, we_v);
            if (VECS[k].wr) begin
                ref_arr[VECS[k].addr] = VECS[k].data;
                check(we_v == EXP_WP, "R5 write pulse cycles", we_v, EXP_WP);
                check(oe_v == 0, "R7 oe during write", oe_v, 0);
                check(lat_v == EXP_WP + EXP_WR + 1, "R8 write latency", lat_v, EXP_WP + EXP_WR + 1);
            end else begin
                check(rd_v == ref_arr[VECS[k].addr], "R2 read data", rd_v, ref_arr[VECS[k].addr]);
                check(oe_v == EXP_RD && we_v == 0, "R3 read window cycles", oe_v, EXP_RD);
                check(lat_v == EXP_RD + EXP_REL + 1, "R4 read latency", lat_v, EXP_RD + EXP_REL + 1);
            end
        end

        // R9: a short request raised only while busy is never started
        begin
            int cs_low;
            @(negedge clk);
            host_req = 1'b1; host_wr = 1'b1; host_addr = 15'h0100; host_wdata = 8'h77;
            @(negedge clk);
            host_wr = 1'b0; host_addr = 15'h0200;
            check(!host_ready, "R9 ready low after accept", host_ready, 0);
            @(negedge clk);
            host_req = 1'b0;
            while (!host_ready) @(negedge clk);
            ref_arr[15'h0100] = 8'h77;
            cs_low = 0;
            repeat (6) begin
                @(negedge clk);
                if (!sram_cs_n || !host_ready) cs_low++;
            end
            check(cs_low == 0, "R9 busy request dropped", cs_low, 0);
        end
        access(1'b0, 15'h0100, 8'h00, rd_v, lat_v, oe_v, we_v);
        check(rd_v == 8'h77, "R9 write before busy request", rd_v, 8'h77);
        access(1'b0, 15'h0200, 8'h00, rd_v, lat_v, oe_v, we_v);
        check(rd_v == ref_arr[15'h0200], "R9 no stray write", rd_v, ref_arr[15'h0200]);

        // R9 held request served after busy; R10 read then write back to back
        access(1'b0, 15'h0300, 8'h00, rd_v, lat_v, oe_v, we_v);
        check(rd_v == ref_arr[15'h0300], "R2 read before turnaround", rd_v, ref_arr[15'h0300]);
        access(1'b1, 15'h0300, 8'hC3, rd_v, lat_v, oe_v, we_v);
        ref_arr[15'h0300] = 8'hC3;
        access(1'b0, 15'h0300, 8'h00, rd_v, lat_v, oe_v, we_v);
        check(rd_v == 8'hC3, "R10 write after read stored", rd_v, 8'hC3);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule